// File: doc/BRIEF.md
# Time-Division Five-Reader Pixel RAM

This block lets five independent read requesters, such as the layers of a display pipeline, share the single read port of a byte-wide dual-port memory. Each requester presents a 20-bit address and a 16-bit tag once per pixel. A fast clock runs at five times the pixel rate and serves the five requests one after another through the read port. Each returned byte is then realigned together with its own address and tag, so that all five results appear together on the output side at a fixed latency counted in whole pixels.

The second memory port belongs to a host on its own clock. The host can write bytes and read them back. The read side never writes the memory. A requester learns the pixel boundary from the phase output: new requests must be stable while the phase is 0.

Top module: `tdm_read_ram`

## Requirements
- R1: While `rst_n` is low, the fast-clock logic resets on each rising edge of `clk`: `pix_phase` is 0 and every result output is 0.
- R2: `pix_phase` steps 0,1,2,3,4,0,… by one on every `clk` edge after reset, so one pixel lasts five fast clocks and phase 0 starts a pixel.
- R3: Result slot n (bits `n*8 +: 8` of `res_data`, `n*20 +: 20` of `res_addr`, `n*16 +: 16` of `res_tag`) carries the memory byte at requester n's address together with that requester's own address and tag. Slots are never swapped.
- R4: Requests are sampled on the `clk` edge that ends a phase-0 cycle. Their results appear on the outputs exactly (PIXEL_PIPE-1)*5 edges later, also on an edge that ends a phase-0 cycle. With the default PIXEL_PIPE of 3 this is 10 edges.
- R5: All result outputs change only on an edge that ends a phase-0 cycle. They hold for the remaining four phases and the next phase 0.
- R6: Values on `req_addr` and `req_tag` during phases 1 to 4 have no effect on any result.
- R7: A byte written by the host becomes visible to requesters that later read the same address.
- R8: A host read returns the byte two `host_clk` edges after the address is sampled. A host read of the address being written in the same cycle returns the old byte.
- R9: Reads through the requester port never change memory contents, as observed through host reads.
- R10: Only the low MEM_AW bits (10 by default) of a request address select the byte. The full 20-bit address is still returned on `res_addr`.
- R11: Several requesters naming the same address in one pixel each receive that same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, five cycles per pixel |
| rst_n | input | 1 | Active-low synchronous reset for the fast-clock domain |
| pix_phase | output | 3 | Current phase within the pixel, 0 to 4 |
| req_addr | input | 100 | Five packed 20-bit request addresses, slot n at `n*20` |
| req_tag | input | 80 | Five packed 16-bit request tags, slot n at `n*16` |
| res_data | output | 40 | Five packed result bytes |
| res_addr | output | 100 | Five packed returned addresses |
| res_tag | output | 80 | Five packed returned tags |
| host_clk | input | 1 | Host port clock |
| host_we | input | 1 | Host write enable |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |

## Verification
A phase counter that skips or repeats a value breaks the sequence on `pix_phase` at the next edge. It also moves every later request into the wrong slot. A wrong select code, a bad delay pipe tap, or a missing meta delay stage shows up as a byte paired with the wrong address or tag. This appears within PIXEL_PIPE pixels of the first request that exposes it. Latency errors of even a single fast clock show up as results that belong to the neighbouring requester or pixel. A read port that writes is caught when the host reads the memory back.

// File: rtl/mprr_pkg.sv
package mprr_pkg;

    // Index of the last stage of the result delay line: the pixel budget in
    // fast clocks, less the select and memory read stages in front of it.
    function automatic int pipe_top(input int pix_pipe, input int nreq,
                                    input int mux_lat, input int ram_lat);
        return ((pix_pipe - 1) * nreq - 1) - mux_lat - ram_lat;
    endfunction

endpackage

// File: rtl/mprr_phase_seq.sv
module mprr_phase_seq #(
    parameter int NREQ = 5,
    parameter int AW   = 20,
    parameter int TW   = 16,
    parameter int PH_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREQ*AW-1:0]         req_addr_i,
    input  logic [NREQ*TW-1:0]         req_tag_i,
    output logic [PH_W-1:0]            phase_o,
    output logic [AW-1:0]              sel_addr_o,
    output logic [TW-1:0]              sel_tag_o,
    output logic [(NREQ-1)*(AW+TW)-1:0] held_o
);
    localparam int MW = AW + TW;
    localparam logic [PH_W-1:0] LAST = PH_W'(NREQ - 1);

    typedef struct packed {
        logic [PH_W-1:0]             phase;
        logic [NREQ-1:1][MW-1:0]     hold;
        logic [MW-1:0]               sel;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.phase = (cur_q.phase == LAST) ? '0 : cur_q.phase + PH_W'(1);
        if (cur_q.phase == '0) begin
            // slot 0 goes straight to the memory, the rest are parked
            nxt_d.sel = {req_addr_i[0 +: AW], req_tag_i[0 +: TW]};
            for (int i = 1; i < NREQ; i++) begin
                nxt_d.hold[i] = {req_addr_i[i*AW +: AW], req_tag_i[i*TW +: TW]};
            end
        end else begin
            for (int i = 1; i < NREQ; i++) begin
                if (cur_q.phase == PH_W'(i)) begin
                    nxt_d.sel = cur_q.hold[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase_o    = cur_q.phase;
    assign sel_addr_o = cur_q.sel[MW-1 -: AW];
    assign sel_tag_o  = cur_q.sel[TW-1:0];
    assign held_o     = cur_q.hold;

endmodule

// File: rtl/mprr_dpram.sv
module mprr_dpram #(
    parameter int DW     = 8,
    parameter int MAW    = 10,
    parameter int RD_LAT = 2
) (
    input  logic           clk_a,
    input  logic [MAW-1:0] addr_a,
    output logic [DW-1:0]  q_a,
    input  logic           clk_b,
    input  logic           we_b,
    input  logic [MAW-1:0] addr_b,
    input  logic [DW-1:0]  d_b,
    output logic [DW-1:0]  q_b
);
    localparam int DEPTH = 1 << MAW;

    logic [DW-1:0]             mem [DEPTH];
    logic [RD_LAT-1:0][DW-1:0] a_stg_q;
    logic [RD_LAT-1:0][DW-1:0] b_stg_q;

    // read-only port: no write path exists on this side
    always_ff @(posedge clk_a) begin
        a_stg_q[0] <= mem[addr_a];
        for (int i = 1; i < RD_LAT; i++) begin
            a_stg_q[i] <= a_stg_q[i-1];
        end
    end

    // host port: the first stage samples the pre-write contents
    always_ff @(posedge clk_b) begin
        if (we_b) begin
            mem[addr_b] <= d_b;
        end
        b_stg_q[0] <= mem[addr_b];
        for (int i = 1; i < RD_LAT; i++) begin
            b_stg_q[i] <= b_stg_q[i-1];
        end
    end

    assign q_a = a_stg_q[RD_LAT-1];
    assign q_b = b_stg_q[RD_LAT-1];

endmodule

// File: rtl/mprr_align.sv
module mprr_align #(
    parameter int NREQ     = 5,
    parameter int AW       = 20,
    parameter int TW       = 16,
    parameter int DW       = 8,
    parameter int PH_W     = 3,
    parameter int PIX_PIPE = 3,
    parameter int MUX_LAT  = 1,
    parameter int RAM_LAT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PH_W-1:0]    phase_i,
    input  logic [AW-1:0]      sel_addr_i,
    input  logic [TW-1:0]      sel_tag_i,
    input  logic [DW-1:0]      rd_data_i,
    output logic [NREQ*DW-1:0] res_data_o,
    output logic [NREQ*AW-1:0] res_addr_o,
    output logic [NREQ*TW-1:0] res_tag_o
);
    localparam int MW  = AW + TW;
    localparam int EW  = DW + MW;
    localparam int TOP = mprr_pkg::pipe_top(PIX_PIPE, NREQ, MUX_LAT, RAM_LAT);

    typedef struct packed {
        logic [RAM_LAT-1:0][MW-1:0] dly;
        logic [TOP:0][EW-1:0]       pipe;
        logic [NREQ-1:0][EW-1:0]    res;
    } al_t;

    al_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        // address and tag wait for the memory to return the byte
        nxt_d.dly[0] = {sel_addr_i, sel_tag_i};
        for (int i = 1; i < RAM_LAT; i++) begin
            nxt_d.dly[i] = cur_q.dly[i-1];
        end
        nxt_d.pipe[0] = {rd_data_i, cur_q.dly[RAM_LAT-1]};
        for (int i = 1; i <= TOP; i++) begin
            nxt_d.pipe[i] = cur_q.pipe[i-1];
        end
        if (phase_i == '0) begin
            for (int n = 0; n < NREQ; n++) begin
                nxt_d.res[n] = cur_q.pipe[TOP-n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_out
        assign res_data_o[g*DW +: DW] = cur_q.res[g][EW-1 -: DW];
        assign res_addr_o[g*AW +: AW] = cur_q.res[g][TW +: AW];
        assign res_tag_o[g*TW +: TW]  = cur_q.res[g][TW-1:0];
    end

endmodule

// File: rtl/tdm_read_ram.sv
module tdm_read_ram #(
    parameter int NUM_REQ    = 5,
    parameter int REQ_AW     = 20,
    parameter int TAG_W      = 16,
    parameter int DATA_W     = 8,
    parameter int MEM_AW     = 10,
    parameter int PIXEL_PIPE = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(NUM_REQ)-1:0] pix_phase,
    input  logic [NUM_REQ*REQ_AW-1:0] req_addr,
    input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
    output logic [NUM_REQ*DATA_W-1:0] res_data,
    output logic [NUM_REQ*REQ_AW-1:0] res_addr,
    output logic [NUM_REQ*TAG_W-1:0]  res_tag,
    input  logic                      host_clk,
    input  logic                      host_we,
    input  logic [MEM_AW-1:0]         host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [DATA_W-1:0]         host_rdata
);
    localparam int PH_W    = $clog2(NUM_REQ);
    localparam int MUX_LAT = 1;
    localparam int RAM_LAT = 2;
    localparam int HOLD_W  = (NUM_REQ - 1) * (REQ_AW + TAG_W);

    logic [REQ_AW-1:0] sel_addr;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] rd_byte;
    logic [HOLD_W-1:0] seq_hold;

    mprr_phase_seq #(
        .NREQ (NUM_REQ),
        .AW   (REQ_AW),
        .TW   (TAG_W),
        .PH_W (PH_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_addr_i (req_addr),
        .req_tag_i  (req_tag),
        .phase_o    (pix_phase),
        .sel_addr_o (sel_addr),
        .sel_tag_o  (sel_tag),
        .held_o     (seq_hold)
    );

    mprr_dpram #(
        .DW     (DATA_W),
        .MAW    (MEM_AW),
        .RD_LAT (RAM_LAT)
    ) u_ram (
        .clk_a  (clk),
        .addr_a (sel_addr[MEM_AW-1:0]),
        .q_a    (rd_byte),
        .clk_b  (host_clk),
        .we_b   (host_we),
        .addr_b (host_addr),
        .d_b    (host_wdata),
        .q_b    (host_rdata)
    );

    mprr_align #(
        .NREQ     (NUM_REQ),
        .AW       (REQ_AW),
        .TW       (TAG_W),
        .DW       (DATA_W),
        .PH_W     (PH_W),
        .PIX_PIPE (PIXEL_PIPE),
        .MUX_LAT  (MUX_LAT),
        .RAM_LAT  (RAM_LAT)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (pix_phase),
        .sel_addr_i (sel_addr),
        .sel_tag_i  (sel_tag),
        .rd_data_i  (rd_byte),
        .res_data_o (res_data),
        .res_addr_o (res_addr),
        .res_tag_o  (res_tag)
    );

endmodule

// File: rtl/tdm_read_ram_chk.sv
module tdm_read_ram_chk #(
    parameter int NUM_REQ = 5,
    parameter int REQ_AW  = 20,
    parameter int TAG_W   = 16,
    parameter int DATA_W  = 8
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [$clog2(NUM_REQ)-1:0]            pix_phase,
    input logic [NUM_REQ*DATA_W-1:0]             res_data,
    input logic [NUM_REQ*REQ_AW-1:0]             res_addr,
    input logic [NUM_REQ*TAG_W-1:0]              res_tag,
    input logic [(NUM_REQ-1)*(REQ_AW+TAG_W)-1:0] seq_hold
);
    localparam int PH_W = $clog2(NUM_REQ);
    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_REQ - 1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pix_phase == '0 && res_data == '0 && res_addr == '0 && res_tag == '0));

    a_r2_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_phase != LAST) |=> (pix_phase == PH_W'($past(pix_phase) + 1'b1)));

    a_r2_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_phase == LAST) |=> (pix_phase == '0));

    a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_phase <= LAST);

    a_r5_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_phase != PH_W'(1)) |-> ($stable(res_data) && $stable(res_addr) && $stable(res_tag)));

    a_r6_parked_requests_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_phase != PH_W'(1)) |-> $stable(seq_hold));

endmodule

bind tdm_read_ram tdm_read_ram_chk #(
    .NUM_REQ (NUM_REQ),
    .REQ_AW  (REQ_AW),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tdm_read_ram_test.sv
module tdm_read_ram_test;
    localparam int NR   = 5;
    localparam int AW   = 20;
    localparam int TW   = 16;
    localparam int DW   = 8;
    localparam int MAW  = 10;
    localparam int PIPE = 3;
    localparam int NV   = 8;
    localparam int MSZ  = 1 << MAW;
    localparam logic [MAW-1:0] WR_ADDR = 10'h155;
    localparam logic [7:0]     WR_BYTE = 8'hC3;

    // request address table: one row per pixel, one column per requester
    localparam logic [AW-1:0] VEC [NV][NR] = '{
        '{20'h00000, 20'h00001, 20'h00002, 20'h00003, 20'h00004},
        '{20'h003FF, 20'h003FE, 20'h00200, 20'h00100, 20'h00080},
        '{20'hFFC05, 20'hABC10, 20'h12F77, 20'h80155, 20'h7E3A0},
        '{20'h00155, 20'h00155, 20'h00155, 20'h00155, 20'h00155},
        '{20'h00040, 20'h00030, 20'h00020, 20'h00010, 20'h00000},
        '{20'h0AAAA, 20'h05555, 20'h0F0F0, 20'h00F0F, 20'h33333},
        '{20'h00007, 20'h003F8, 20'h00007, 20'h003F8, 20'h00100},
        '{20'h12345, 20'h23456, 20'h34567, 20'h45678, 20'h56789}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        pix_phase;
    logic [NR*AW-1:0]  req_addr = '0;
    logic [NR*TW-1:0]  req_tag = '0;
    logic [NR*DW-1:0]  res_data;
    logic [NR*AW-1:0]  res_addr;
    logic [NR*TW-1:0]  res_tag;
    logic              host_clk = 1'b0;
    logic              host_we = 1'b0;
    logic [MAW-1:0]    host_addr = '0;
    logic [DW-1:0]     host_wdata = '0;
    logic [DW-1:0]     host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [MSZ];

    always #10 clk = ~clk;
    always #17 host_clk = ~host_clk;

    tdm_read_ram #(.PIXEL_PIPE(PIPE), .MEM_AW(MAW)) uut (
        .clk(clk), .rst_n(rst_n), .pix_phase(pix_phase),
        .req_addr(req_addr), .req_tag(req_tag),
        .res_data(res_data), .res_addr(res_addr), .res_tag(res_tag),
        .host_clk(host_clk), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + (a >> 5) + 8'h5A);
    endfunction

    function automatic logic [TW-1:0] tag_of(input int k, input int n);
        return 16'hA000 | TW'(k << 4) | TW'(n);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_phase(input int ph);
        do @(negedge clk); while (int'(pix_phase) != ph);
    endtask

    task automatic host_write(input logic [MAW-1:0] a, input logic [7:0] d);
        @(negedge host_clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge host_clk);
        host_we = 1'b0;
        model[a] = d;
    endtask

    task automatic host_read(input logic [MAW-1:0] a, output logic [7:0] d);
        @(negedge host_clk);
        host_we = 1'b0; host_addr = a;
        @(posedge host_clk);
        @(posedge host_clk);
        @(negedge host_clk);
        d = host_rdata;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic [2:0] prev;
        logic [NR*DW-1:0] snap_d;
        logic [NR*AW-1:0] snap_a;
        logic [NR*TW-1:0] snap_t;
        snap_d = '0; snap_a = '0; snap_t = '0;

        // R1: state while reset is held
        repeat (4) @(negedge clk);
        chk("R1 phase", 64'(pix_phase), 64'd0);
        chk("R1 data", 64'(res_data), 64'd0);
        chk("R1 addr/tag", 64'(res_addr ^ 100'(res_tag)), 64'd0);
        rst_n = 1'b1;

        // R2: phase sequence
        @(negedge clk);
        prev = pix_phase;
        chk("R2 first phase", 64'(prev), 64'd1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R2 step", 64'(pix_phase), 64'((prev == 3'd4) ? 3'd0 : prev + 3'd1));
            prev = pix_phase;
        end

        // preload every byte through the host port
        for (int a = 0; a < MSZ; a++) host_write(MAW'(a), pat(a));

        // R8: read during write returns the old byte, then the new one
        @(negedge host_clk);
        host_we = 1'b1; host_addr = WR_ADDR; host_wdata = WR_BYTE;
        @(posedge host_clk);
        @(negedge host_clk);
        host_we = 1'b0;
        @(posedge host_clk);
        @(negedge host_clk);
        chk("R8 old data on collision", 64'(host_rdata), 64'(pat(int'(WR_ADDR))));
        model[WR_ADDR] = WR_BYTE;
        host_read(WR_ADDR, rb);
        chk("R8 new data after write", 64'(rb), 64'(WR_BYTE));
        host_read(10'h3FF, rb);
        chk("R8 plain read", 64'(rb), 64'(pat(10'h3FF)));

        // table walk: rows at phase 0, junk during phases 1..3
        for (int k = 0; k < NV + PIPE; k++) begin
            wait_phase(4);
            if (k > 0) begin
                chk("R5 data held", 64'(res_data), 64'(snap_d));
                chk("R5 addr held", 64'(res_addr), 64'(snap_a));
                chk("R5 tag held", 64'(res_tag), 64'(snap_t));
            end
            for (int n = 0; n < NR; n++) begin
                req_addr[n*AW +: AW] = (k < NV) ? VEC[k][n] : '0;
                req_tag[n*TW +: TW]  = (k < NV) ? tag_of(k, n) : '0;
            end
            wait_phase(1);
            if (k - (PIPE - 1) >= 0 && k - (PIPE - 1) < NV) begin
                int j;
                string lbl;
                j = k - (PIPE - 1);
                lbl = (j == 3) ? "R11 R7" : (j == 2) ? "R10 R7" : "R3 R4 R6";
                for (int n = 0; n < NR; n++) begin
                    chk(lbl, 64'(res_data[n*DW +: DW]),
                        64'(model[int'(VEC[j][n][MAW-1:0])]));
                    chk("R10 R3 addr", 64'(res_addr[n*AW +: AW]), 64'(VEC[j][n]));
                    chk("R3 R4 tag", 64'(res_tag[n*TW +: TW]), 64'(tag_of(j, n)));
                end
            end
            snap_d = res_data; snap_a = res_addr; snap_t = res_tag;
            req_addr = ~req_addr;
            req_tag  = ~req_tag;
        end

        // R9: requester reads left the memory untouched
        for (int r = 0; r < 3; r++) begin
            for (int n = 0; n < NR; n++) begin
                host_read(VEC[r][n][MAW-1:0], rb);
                chk("R9 contents intact", 64'(rb), 64'(model[int'(VEC[r][n][MAW-1:0])]));
            end
        end

        summary();
        $finish;
    end

endmodule